// File: doc/BRIEF.md
# Hibernate Power-Mode Sequencer

This block runs the deep-sleep state of a small embedded processor system on the always-on real-time-clock clock. While the system is asleep, the sequencer removes the low-voltage core supply and holds the processor in reset. It drives the data bus low so the bus does not float. It watches four asynchronous wake sources. When an enabled source fires, the core rail comes back up. The processor reset is held for a settling window and then released, so software always restarts from the reset vector. It never resumes after the instruction that asked for sleep. A sticky cause register records which source woke the system, and software clears it after boot.

After the real-time-clock reset is released, the block starts asleep in a cold state. The memory supply also stays off there, so external SDRAM cannot fight the bus before it is set up. The cold state ends only when the power button is pressed after a short guard window. Later sleep periods keep the memory supply on. A software sleep request that arrives while an enabled wake source is already active is refused, and the system stays running.

Top module: `hib_seq`

## Requirements
- R1: During reset and right after it, core_pwr_en=0, mem_pwr_en=0, sys_rst_n=0, bus_drive_low=1 and wake_cause=0.
- R2: The power button has no effect until GUARD (default 3) clock cycles have passed since reset release. A press that is seen only inside that window leaves the block in its cold state.
- R3: A qualified button press in the cold state raises core_pwr_en and mem_pwr_en 3 cycles after the input changes. sys_rst_n then stays low for exactly RST_HOLD cycles (default 8) with the core supply on, and rises after that.
- R4: A one-cycle hib_req while running, with no enabled source active, makes core_pwr_en=0, sys_rst_n=0 and bus_drive_low=1 on the next cycle. mem_pwr_en stays 1.
- R5: While asleep, an enabled active source wakes the block within 3 cycles of the input change. A source whose wake_en bit is 0 is ignored. wake_en bits are: bit0 button, bit1 timer, bit2 carrier detect, bit3 GPIO.
- R6: When several enabled sources are active together, only the highest-priority one is recorded in wake_cause. The priority order is button, then timer, then carrier detect, then GPIO. wake_cause uses the same bit positions as wake_en.
- R7: wake_cause bits are sticky across wakes and are cleared only by cause_clr.
- R8: A hib_req that arrives while any enabled source is active is refused, and the block stays running (core_pwr_en=1, sys_rst_n=1).
- R9: A GPIO line wakes the block only if its bit in gpio_wake_mask is 1.
- R10: The carrier-detect input cd_n is active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on real-time-clock clock |
| rst_n | input | 1 | Real-time-clock reset, active low, asynchronous |
| hib_req | input | 1 | Software sleep request, one-cycle pulse |
| pwr_btn | input | 1 | Power button, active high, asynchronous |
| tmr_irq | input | 1 | Elapsed-time alarm, active high, asynchronous |
| cd_n | input | 1 | Modem carrier detect, active low, asynchronous |
| gpio_irq | input | NGPIO | GPIO interrupt lines, active high, asynchronous |
| gpio_wake_mask | input | NGPIO | Selects which GPIO lines may wake |
| wake_en | input | 4 | Per-source wake enables |
| cause_clr | input | 1 | Clears wake_cause |
| core_pwr_en | output | 1 | Core (low-voltage) supply enable |
| mem_pwr_en | output | 1 | External memory supply enable |
| sys_rst_n | output | 1 | Processor reset, active low |
| bus_drive_low | output | 1 | Drive data bus low while asleep |
| wake_cause | output | 4 | Sticky record of the wake source |

## Verification
A wrong state register shows up at the supply and reset pins: the core rail is in the wrong state, or sys_rst_n rises early or late. The pins are compared cycle by cycle against the count of synchronizer stages plus the settle window, so a one-cycle slip in the hold counter is caught at the exact edge. A wrong priority or mask decision shows in wake_cause within three cycles of the input change. A missing sticky update shows on the second wake of a chained sequence. A lost guard or lost rejection shows as a core rail that switches when it should not.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_COLD   = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } hib_state_e;

  localparam int SRC_N    = 4;
  localparam int SRC_BTN  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_CD   = 2;
  localparam int SRC_GPIO = 3;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/hib_guard.sv
module hib_guard #(
  parameter int GUARD = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int GW = $clog2(GUARD + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GUARD);

  logic [GW-1:0] cnt_q;
  logic [GW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != G_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = ~cnt_en;
endmodule

// File: rtl/hib_wake_arb.sv
module hib_wake_arb
  import hib_pkg::*;
#(
  parameter int NGPIO = 8
) (
  input  logic [SRC_N-1:0] wake_en,
  input  logic             btn_ok,
  input  logic             tmr_s,
  input  logic             cd_s,
  input  logic [NGPIO-1:0] gpio_s,
  input  logic [NGPIO-1:0] gpio_mask,
  output logic [SRC_N-1:0] win,
  output logic             pending
);
  logic [SRC_N-1:0] raw;

  always_comb begin
    raw           = '0;
    raw[SRC_BTN]  = btn_ok;
    raw[SRC_TMR]  = tmr_s;
    raw[SRC_CD]   = cd_s;
    raw[SRC_GPIO] = |(gpio_s & gpio_mask);
    raw           = raw & wake_en;
  end

  // lowest index = highest priority: isolate the lowest set bit
  assign win     = raw & (~raw + 1'b1);
  assign pending = |raw;
endmodule

// File: rtl/hib_seq.sv
module hib_seq
  import hib_pkg::*;
#(
  parameter int NGPIO    = 8,
  parameter int GUARD    = 3,
  parameter int RST_HOLD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hib_req,
  input  logic             pwr_btn,
  input  logic             tmr_irq,
  input  logic             cd_n,
  input  logic [NGPIO-1:0] gpio_irq,
  input  logic [NGPIO-1:0] gpio_wake_mask,
  input  logic [SRC_N-1:0] wake_en,
  input  logic             cause_clr,
  output logic             core_pwr_en,
  output logic             mem_pwr_en,
  output logic             sys_rst_n,
  output logic             bus_drive_low,
  output logic [SRC_N-1:0] wake_cause
);
  localparam int SW  = NGPIO + 3;
  localparam int HCW = $clog2(RST_HOLD + 1);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(RST_HOLD - 1);

  // synchronized wake inputs (carrier detect inverted to active high)
  logic [SW-1:0]    raw_in;
  logic [SW-1:0]    syn;
  logic             btn_s, tmr_s, cd_s;
  logic [NGPIO-1:0] gpio_s;

  assign raw_in = {gpio_irq, ~cd_n, tmr_irq, pwr_btn};

  hib_sync #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn)
  );

  assign btn_s  = syn[0];
  assign tmr_s  = syn[1];
  assign cd_s   = syn[2];
  assign gpio_s = syn[SW-1:3];

  logic guard_done;
  logic btn_ok;

  hib_guard #(.GUARD(GUARD)) u_guard (
    .clk  (clk),
    .rst_n(rst_n),
    .done (guard_done)
  );

  assign btn_ok = btn_s & guard_done;

  logic [SRC_N-1:0] win;
  logic             pending;

  hib_wake_arb #(.NGPIO(NGPIO)) u_arb (
    .wake_en  (wake_en),
    .btn_ok   (btn_ok),
    .tmr_s    (tmr_s),
    .cd_s     (cd_s),
    .gpio_s   (gpio_s),
    .gpio_mask(gpio_wake_mask),
    .win      (win),
    .pending  (pending)
  );

  // sequencer state
  hib_state_e       state_q, state_d;
  logic [HCW-1:0]   hold_q, hold_d;
  logic             mem_q, mem_d;
  logic [SRC_N-1:0] cause_q, cause_d;
  logic             wake_now;

  assign wake_now = (state_q == ST_SLEEP) && pending;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLD:   if (btn_ok)                 state_d = ST_SETTLE;
      ST_SLEEP:  if (pending)                state_d = ST_SETTLE;
      ST_SETTLE: if (hold_q == HOLD_LAST)    state_d = ST_RUN;
      ST_RUN:    if (hib_req && !pending)    state_d = ST_SLEEP;
      default:                               state_d = ST_COLD;
    endcase
  end

  always_comb begin
    hold_d = '0;
    if (state_q == ST_SETTLE) hold_d = hold_q + 1'b1;
  end

  always_comb begin
    mem_d = mem_q;
    if (state_q == ST_COLD && btn_ok) mem_d = 1'b1;
  end

  always_comb begin
    cause_d = cause_clr ? '0 : cause_q;
    if (wake_now) cause_d = cause_d | win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLD;
      hold_q  <= '0;
      mem_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      mem_q   <= mem_d;
      cause_q <= cause_d;
    end
  end

  assign core_pwr_en   = (state_q == ST_SETTLE) || (state_q == ST_RUN);
  assign sys_rst_n     = (state_q == ST_RUN);
  assign bus_drive_low = (state_q == ST_COLD) || (state_q == ST_SLEEP);
  assign mem_pwr_en    = mem_q;
  assign wake_cause    = cause_q;
endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk #(
  parameter int RST_HOLD = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       core_pwr_en,
  input logic       mem_pwr_en,
  input logic       sys_rst_n,
  input logic       bus_drive_low,
  input logic       cause_clr,
  input logic [3:0] wake_cause
);
  localparam int OW = $clog2(RST_HOLD + 1);
  localparam logic [OW-1:0] ON_MAX = OW'(RST_HOLD);

  logic [OW-1:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 on_cnt <= '0;
    else if (!core_pwr_en)      on_cnt <= '0;
    else if (on_cnt != ON_MAX)  on_cnt <= on_cnt + 1'b1;
  end

  // R3: reset released only after the rail has been on for the hold window
  assert_rst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (on_cnt == ON_MAX));

  // R3: reset still held on the cycle after the rail comes up
  assert_rst_after_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr_en) |=> !sys_rst_n);

  // R4: processor never out of reset with the core rail off
  assert_rst_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_en |-> !sys_rst_n);

  // R4: bus is driven low only while the core rail is off
  assert_bus_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_low |-> !core_pwr_en);

  // R4: memory supply, once on, stays on
  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pwr_en |=> mem_pwr_en);

  // R7: cause bits never drop without a clear
  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_clr |=> ((wake_cause & $past(wake_cause)) == $past(wake_cause)));

  // R6: at most one new cause bit per cycle
  assert_cause_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause & ~$past(wake_cause)));
endmodule

bind hib_seq hib_seq_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_pwr_en  (core_pwr_en),
  .mem_pwr_en   (mem_pwr_en),
  .sys_rst_n    (sys_rst_n),
  .bus_drive_low(bus_drive_low),
  .cause_clr    (cause_clr),
  .wake_cause   (wake_cause)
);

// File: tb/hib_seq_test.sv
module hib_seq_test;
  localparam int NGPIO    = 8;
  localparam int RST_HOLD = 8;

  logic             clk;
  logic             rst_n;
  logic             hib_req;
  logic             pwr_btn;
  logic             tmr_irq;
  logic             cd_n;
  logic [NGPIO-1:0] gpio_irq;
  logic [NGPIO-1:0] gpio_wake_mask;
  logic [3:0]       wake_en;
  logic             cause_clr;
  logic             core_pwr_en;
  logic             mem_pwr_en;
  logic             sys_rst_n;
  logic             bus_drive_low;
  logic [3:0]       wake_cause;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  hib_seq #(.NGPIO(NGPIO), .GUARD(3), .RST_HOLD(RST_HOLD)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .hib_req       (hib_req),
    .pwr_btn       (pwr_btn),
    .tmr_irq       (tmr_irq),
    .cd_n          (cd_n),
    .gpio_irq      (gpio_irq),
    .gpio_wake_mask(gpio_wake_mask),
    .wake_en       (wake_en),
    .cause_clr     (cause_clr),
    .core_pwr_en   (core_pwr_en),
    .mem_pwr_en    (mem_pwr_en),
    .sys_rst_n     (sys_rst_n),
    .bus_drive_low (bus_drive_low),
    .wake_cause    (wake_cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0]       en;
    logic             btn;
    logic             tmr;
    logic             cdn;
    logic [NGPIO-1:0] gpio;
    logic [NGPIO-1:0] mask;
    logic             wake;
    logic [3:0]       cause;
  } vec_t;

  // R5 R6 R9 R10 scenarios
  localparam vec_t VECS [0:7] = '{
    '{4'hF, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 4'b0010},
    '{4'hF, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 4'b0100},
    '{4'hF, 1'b0, 1'b0, 1'b1, 8'h08, 8'h08, 1'b1, 4'b1000},
    '{4'hF, 1'b0, 1'b0, 1'b1, 8'h08, 8'hF7, 1'b0, 4'b0000},
    '{4'hD, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    '{4'hF, 1'b0, 1'b1, 1'b0, 8'h01, 8'hFF, 1'b1, 4'b0010},
    '{4'hF, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 4'b0001},
    '{4'hE, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 4'b0100}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    pwr_btn  = 1'b0;
    tmr_irq  = 1'b0;
    cd_n     = 1'b1;
    gpio_irq = '0;
  endtask

  task automatic pulse_clr();
    cause_clr = 1'b1; step(1); cause_clr = 1'b0;
  endtask

  task automatic sleep_now();
    hib_req = 1'b1; step(1); hib_req = 1'b0;
  endtask

  task automatic timer_wake();
    tmr_irq = 1'b1; step(4); tmr_irq = 1'b0;
    step(RST_HOLD + 2);
  endtask

  initial begin
    rst_n = 1'b0; hib_req = 1'b0; cause_clr = 1'b0;
    idle();
    gpio_wake_mask = '0;
    wake_en = 4'hF;
    pwr_btn = 1'b1;
    step(3);
    // R1: reset state
    chk("R1 core", 32'(core_pwr_en), 0);
    chk("R1 mem", 32'(mem_pwr_en), 0);
    chk("R1 sysrst", 32'(sys_rst_n), 0);
    chk("R1 buslow", 32'(bus_drive_low), 1);
    chk("R1 cause", 32'(wake_cause), 0);

    // R2: button seen only inside guard window is ignored
    rst_n = 1'b1;
    step(1);
    pwr_btn = 1'b0;
    step(6);
    chk("R2 core stays off", 32'(core_pwr_en), 0);
    chk("R2 mem stays off", 32'(mem_pwr_en), 0);

    // R3: cold start with qualified press
    pwr_btn = 1'b1;
    step(3);
    chk("R3 core on", 32'(core_pwr_en), 1);
    chk("R3 mem on", 32'(mem_pwr_en), 1);
    chk("R3 rst held", 32'(sys_rst_n), 0);
    pwr_btn = 1'b0;
    step(RST_HOLD - 1);
    chk("R3 rst held last", 32'(sys_rst_n), 0);
    step(1);
    chk("R3 rst released", 32'(sys_rst_n), 1);
    chk("R3 cause none", 32'(wake_cause), 0);
    step(3);

    // vector table walk
    for (int i = 0; i < 8; i++) begin
      idle();
      wake_en        = VECS[i].en;
      gpio_wake_mask = VECS[i].mask;
      pulse_clr();
      sleep_now();
      chk("R4 core off", 32'(core_pwr_en), 0);
      chk("R4 mem stays", 32'(mem_pwr_en), 1);
      chk("R4 bus low", 32'(bus_drive_low), 1);
      pwr_btn  = VECS[i].btn;
      tmr_irq  = VECS[i].tmr;
      cd_n     = VECS[i].cdn;
      gpio_irq = VECS[i].gpio;
      step(3);
      chk($sformatf("R5 R6 R9 R10 wake v%0d", i), 32'(core_pwr_en), 32'(VECS[i].wake));
      chk($sformatf("R6 cause v%0d", i), 32'(wake_cause), 32'(VECS[i].cause));
      idle();
      step(3);
      if (!VECS[i].wake) begin
        wake_en = 4'hF;
        timer_wake();
      end else begin
        step(RST_HOLD + 2);
      end
      chk($sformatf("R3 running v%0d", i), 32'(sys_rst_n), 1);
    end

    // R8: request refused while a source is active
    idle(); wake_en = 4'hF; pulse_clr();
    tmr_irq = 1'b1;
    step(3);
    sleep_now();
    step(1);
    chk("R8 core kept", 32'(core_pwr_en), 1);
    chk("R8 run kept", 32'(sys_rst_n), 1);
    tmr_irq = 1'b0;
    step(4);

    // R7: sticky across two wakes, then cleared
    sleep_now();
    timer_wake();
    sleep_now();
    cd_n = 1'b0; step(4); cd_n = 1'b1;
    chk("R7 sticky", 32'(wake_cause), 32'h6);
    step(RST_HOLD + 2);
    chk("R7 still set", 32'(wake_cause), 32'h6);
    pulse_clr();
    chk("R7 cleared", 32'(wake_cause), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule